// File: doc/BRIEF.md
# Multichannel Receive Reset Sequencer

This block orders the resets for the receive lanes of a serial transceiver. Every lane has an analog reset, a digital reset and a ready flag. All of them are clocked by one controller clock. The analog reset follows the global reset and the lane's calibration-busy flag. The digital reset is held while any of these is true: the global reset is asserted, the lane is calibrating, or the lane has lost lock to incoming data while manual mode is off. Once every such cause has cleared, the digital reset is released only after a fixed countdown. The ready flag then rises a fixed number of cycles after that release.

Each lane runs its own four-state machine. The states are CH_RESET, CH_COUNT, CH_SETTLE and CH_READY, and they move as follows:

- A lane leaves CH_RESET for CH_COUNT on the first cycle in which no cause is present.
- CH_COUNT advances to CH_SETTLE after HOLD_CYC cycles.
- CH_SETTLE advances to CH_READY after READY_DLY cycles.
- From any state, a cause returns the lane to CH_RESET with its counter cleared.

The digital reset and the ready flag also respond to a cause combinationally in the same cycle. Because of this, one lane can be recovering while another stays held. The transmit PLL power-down outputs follow the global reset and remain high for PLL_MIN cycles after its internal release.

The calibration-busy, lock and manual inputs each pass through a two-flop synchronizer. The global reset sets the block asynchronously and is released through two flops.

Top module: `rx_rst_seq`

## Requirements
- R1: `ana_rst[i]` is high exactly when the internal reset is active or the synchronized `cal_busy[i]` is high.
- R2: `dig_rst[i]` is high whenever `ana_rst[i]` is high. This includes the internal reset and calibration-busy cases.
- R3: A synchronized low on `lock[i]` forces `dig_rst[i]` high and `ready[i]` low when synchronized `manual` is 0. When `manual` is 1, loss of lock has no effect on either output.
- R4: `dig_rst[i]` goes low in the cycle where the lane's synchronized causes have been clear for HOLD_CYC+2 consecutive cycles. It stays high before that cycle.
- R5: `ready[i]` is high exactly when the causes have been clear for more than HOLD_CYC+READY_DLY+1 consecutive cycles. It is therefore never high together with `dig_rst[i]`.
- R6: A cause arriving at any point in the sequence raises `dig_rst[i]` and drops `ready[i]` in that same cycle. The complete countdown then restarts from zero.
- R7: Lanes are independent. A cause on lane i changes no output of any other lane.
- R8: `cal_busy`, `lock` and `manual` affect the outputs only after two rising clock edges.
- R9: Raising `rst_in` sets every `ana_rst` and `dig_rst` at once, without waiting for a clock edge. The internal reset is released on the second rising edge after `rst_in` falls.
- R10: Every `pll_pd` bit is high while the internal reset is active. Each bit stays high for a further PLL_MIN cycles after the internal reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_in | input | 1 | Global reset, active high, asynchronous assert |
| cal_busy | input | NCH | Per-lane calibration in progress |
| lock | input | NCH | Per-lane locked-to-data flag |
| manual | input | 1 | 1 = ignore loss of lock |
| ana_rst | output | NCH | Per-lane analog reset |
| dig_rst | output | NCH | Per-lane digital reset |
| ready | output | NCH | Per-lane sequence complete |
| pll_pd | output | NPLL | Transmit PLL power-down |

## Verification
The first pattern brings all lanes out of reset with lock held steady. This pins down the exact release cycle of the countdown and of the ready delay. A short lock drop with manual mode off is compared against the same drop with manual mode on, which separates forced reset from ignored loss of lock. Two calibration pulses are then applied on one lane, the second arriving mid-countdown. This shows whether the countdown restarts in full or resumes, and whether the other lanes stay untouched. A global reset applied during operation shows the asynchronous assertion, the two-edge release and the PLL power-down hold.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;
    typedef enum logic [1:0] {
        CH_RESET  = 2'd0,
        CH_COUNT  = 2'd1,
        CH_SETTLE = 2'd2,
        CH_READY  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/rxrs_rst_sync.sv
module rxrs_rst_sync (
    input  logic clk,
    input  logic arst_in,
    output logic rst_o
);
    logic stage1, stage2;

    always_ff @(posedge clk or posedge arst_in) begin
        if (arst_in) begin
            stage1 <= 1'b1;
            stage2 <= 1'b1;
        end else begin
            stage1 <= 1'b0;
            stage2 <= stage1;
        end
    end

    assign rst_o = stage2;
endmodule

// File: rtl/rxrs_sync2.sv
module rxrs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rxrs_chan.sv
module rxrs_chan
    import rxrs_pkg::*;
#(
    parameter int HOLD_CYC  = 32,
    parameter int READY_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cal_s,
    input  logic lock_s,
    input  logic manual_s,
    output logic dig_rst,
    output logic ready
);
    localparam int LIM = (HOLD_CYC > READY_DLY) ? HOLD_CYC : READY_DLY;
    localparam int CW  = $clog2(LIM + 1);

    ch_state_e      st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           cause;

    assign cause = rst | cal_s | (~lock_s & ~manual_s);

    // next-state logic
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (cause) begin
            st_n  = CH_RESET;
            cnt_n = '0;
        end else begin
            unique case (st)
                CH_RESET: begin
                    st_n  = CH_COUNT;
                    cnt_n = '0;
                end
                CH_COUNT: begin
                    if (cnt == CW'(HOLD_CYC - 1)) begin
                        st_n  = CH_SETTLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                CH_SETTLE: begin
                    if (cnt == CW'(READY_DLY - 1)) begin
                        st_n  = CH_READY;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                CH_READY: begin
                    st_n  = CH_READY;
                end
                default: begin
                    st_n  = CH_RESET;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st  <= CH_RESET;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            CH_RESET, CH_COUNT: begin
                dig_rst = 1'b1;
                ready   = 1'b0;
            end
            CH_SETTLE: begin
                dig_rst = cause;
                ready   = 1'b0;
            end
            CH_READY: begin
                dig_rst = cause;
                ready   = ~cause;
            end
            default: begin
                dig_rst = 1'b1;
                ready   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rxrs_pll_pd.sv
module rxrs_pll_pd #(
    parameter int NPLL    = 2,
    parameter int PLL_MIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [NPLL-1:0] pll_pd
);
    localparam int CW = $clog2(PLL_MIN + 1) + 1;

    logic [CW-1:0] held;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            held <= '0;
        end else if (held != CW'(PLL_MIN)) begin
            held <= held + 1'b1;
        end
    end

    assign pll_pd = {NPLL{held != CW'(PLL_MIN)}};
endmodule

// File: rtl/rx_rst_seq.sv
module rx_rst_seq #(
    parameter int NCH       = 4,
    parameter int NPLL      = 2,
    parameter int HOLD_CYC  = 32,
    parameter int READY_DLY = 4,
    parameter int PLL_MIN   = 8
) (
    input  logic            clk,
    input  logic            rst_in,
    input  logic [NCH-1:0]  cal_busy,
    input  logic [NCH-1:0]  lock,
    input  logic            manual,
    output logic [NCH-1:0]  ana_rst,
    output logic [NCH-1:0]  dig_rst,
    output logic [NCH-1:0]  ready,
    output logic [NPLL-1:0] pll_pd
);
    logic           rst_s;
    logic [NCH-1:0] cal_s, lock_s;
    logic           manual_s;

    rxrs_rst_sync u_rsync (
        .clk     (clk),
        .arst_in (rst_in),
        .rst_o   (rst_s)
    );

    rxrs_sync2 #(.W(2 * NCH + 1)) u_isync (
        .clk (clk),
        .rst (rst_s),
        .d   ({manual, lock, cal_busy}),
        .q   ({manual_s, lock_s, cal_s})
    );

    assign ana_rst = {NCH{rst_s}} | cal_s;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        rxrs_chan #(
            .HOLD_CYC  (HOLD_CYC),
            .READY_DLY (READY_DLY)
        ) u_chan (
            .clk      (clk),
            .rst      (rst_s),
            .cal_s    (cal_s[g]),
            .lock_s   (lock_s[g]),
            .manual_s (manual_s),
            .dig_rst  (dig_rst[g]),
            .ready    (ready[g])
        );
    end

    rxrs_pll_pd #(
        .NPLL    (NPLL),
        .PLL_MIN (PLL_MIN)
    ) u_pll (
        .clk    (clk),
        .rst    (rst_s),
        .pll_pd (pll_pd)
    );
endmodule

// File: rtl/rxrs_chk.sv
module rxrs_chk #(
    parameter int NCH  = 4,
    parameter int NPLL = 2
) (
    input logic            clk,
    input logic            rst_in,
    input logic            rs,
    input logic [NCH-1:0]  ana_rst,
    input logic [NCH-1:0]  dig_rst,
    input logic [NCH-1:0]  ready,
    input logic [NPLL-1:0] pll_pd
);
    // R2
    ana_in_dig_chk: assert property (@(posedge clk) disable iff (rst_in)
        (ana_rst & ~dig_rst) == '0);

    // R5
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst_in)
        (ready & dig_rst) == '0);

    // R5
    ready_after_rel_chk: assert property (@(posedge clk) disable iff (rst_in)
        (ready & ~$past(ready) & $past(dig_rst)) == '0);

    // R9
    rs_ana_chk: assert property (@(posedge clk) disable iff (rst_in)
        rs |-> (ana_rst == '1));

    // R10
    rs_pll_chk: assert property (@(posedge clk) disable iff (rst_in)
        rs |-> (pll_pd == '1));
endmodule

bind rx_rst_seq rxrs_chk #(.NCH(NCH), .NPLL(NPLL)) u_chk (
    .clk     (clk),
    .rst_in  (rst_in),
    .rs      (rst_s),
    .ana_rst (ana_rst),
    .dig_rst (dig_rst),
    .ready   (ready),
    .pll_pd  (pll_pd)
);

// File: tb/sim_rx_rst_seq.sv
module sim_rx_rst_seq;
    localparam int NCH = 4, NPLL = 2, HOLD = 32, RDY = 4, PMIN = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_in = 1'b0;
    logic [NCH-1:0]  cal = '0, lock = '0;
    logic            manual = 1'b0;
    logic [NCH-1:0]  ana_rst, dig_rst, ready;
    logic [NPLL-1:0] pll_pd;

    rx_rst_seq #(.NCH(NCH), .NPLL(NPLL), .HOLD_CYC(HOLD), .READY_DLY(RDY), .PLL_MIN(PMIN)) u0 (
        .clk(clk), .rst_in(rst_in), .cal_busy(cal), .lock(lock), .manual(manual),
        .ana_rst(ana_rst), .dig_rst(dig_rst), .ready(ready), .pll_pd(pll_pd)
    );

    // reference model: delayed copies of the inputs and clear-run counters
    logic           m_r1 = 1'b1, m_r2 = 1'b1;
    logic [NCH-1:0] c1 = '0, c2 = '0, l1 = '0, l2 = '0;
    logic           n1 = 1'b0, n2 = 1'b0;
    int run [NCH];
    int prun = 0;
    int total = 0, bad = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst_in | m_r2) begin
            c1 <= '0; c2 <= '0; l1 <= '0; l2 <= '0; n1 <= 1'b0; n2 <= 1'b0;
        end else begin
            c1 <= cal; c2 <= c1; l1 <= lock; l2 <= l1; n1 <= manual; n2 <= n1;
        end
        if (rst_in) begin
            m_r1 <= 1'b1; m_r2 <= 1'b1;
        end else begin
            m_r1 <= 1'b0; m_r2 <= m_r1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        logic rs_m;
        logic cause;
        @(negedge clk);
        rs_m = rst_in | m_r2;
        prun = rs_m ? 0 : prun + 1;
        for (int c = 0; c < NCH; c++) begin
            cause  = rs_m | c2[c] | (~l2[c] & ~n2);
            run[c] = cause ? 0 : run[c] + 1;
            chk(ana_rst[c] == (rs_m | c2[c]), "R1", $sformatf("ana_rst[%0d]", c), ana_rst[c], rs_m | c2[c]);
            chk(dig_rst[c] == (run[c] <= HOLD + 1), "R4", $sformatf("dig_rst[%0d]", c), dig_rst[c], run[c] <= HOLD + 1);
            chk(ready[c] == (run[c] > HOLD + RDY + 1), "R5", $sformatf("ready[%0d]", c), ready[c], run[c] > HOLD + RDY + 1);
        end
        for (int p = 0; p < NPLL; p++)
            chk(pll_pd[p] == (prun <= PMIN), "R10", $sformatf("pll_pd[%0d]", p), pll_pd[p], prun <= PMIN);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) run[c] = 0;
        #1 rst_in = 1'b1;
        ticks(5);
        // R9 reset state
        chk(ana_rst == '1 && dig_rst == '1 && ready == '0, "R9", "reset state", {ana_rst, dig_rst, ready}, {4'hF, 4'hF, 4'h0});
        rst_in = 1'b0;
        lock   = '1;
        ticks(50);
        chk(ready == '1, "R5", "all lanes ready", ready, 4'hF);

        // R3 loss of lock with manual off
        lock[0] = 1'b0;
        ticks(2);
        chk(dig_rst[0] == 1'b1 && ready[0] == 1'b0, "R3", "lane0 lock lost", {dig_rst[0], ready[0]}, 2'b10);
        chk(ready[3:1] == 3'b111, "R7", "other lanes untouched", ready[3:1], 3'b111);
        tick();
        lock[0] = 1'b1;
        ticks(45);

        // R3 loss of lock ignored with manual on
        manual = 1'b1;
        ticks(3);
        lock[2] = 1'b0;
        ticks(5);
        chk(dig_rst[2] == 1'b0 && ready[2] == 1'b1, "R3", "manual ignores lock", {dig_rst[2], ready[2]}, 2'b01);
        lock[2] = 1'b1;
        ticks(3);
        manual = 1'b0;
        ticks(3);

        // R8 two-edge delay, R2 and R7 on a calibration pulse
        cal[1] = 1'b1;
        tick();
        chk(ana_rst[1] == 1'b0, "R8", "cal after one edge", ana_rst[1], 0);
        tick();
        chk(ana_rst[1] == 1'b1 && dig_rst[1] == 1'b1, "R2", "cal asserts both", {ana_rst[1], dig_rst[1]}, 2'b11);
        chk(dig_rst[0] == 1'b0 && ana_rst[0] == 1'b0, "R7", "lane0 unaffected", {dig_rst[0], ana_rst[0]}, 2'b00);
        cal[1] = 1'b0;
        ticks(20);

        // R6 second pulse mid countdown restarts it fully
        cal[1] = 1'b1;
        tick();
        cal[1] = 1'b0;
        ticks(HOLD + 1);
        chk(dig_rst[1] == 1'b1, "R6", "countdown restarted", dig_rst[1], 1);
        ticks(10);
        chk(dig_rst[1] == 1'b0 && ready[1] == 1'b1, "R6", "lane1 recovered", {dig_rst[1], ready[1]}, 2'b01);

        // R7 lane3 held by calibration, others stay ready
        cal[3] = 1'b1;
        ticks(40);
        chk(ready == 4'b0111, "R7", "lane3 held", ready, 4'b0111);
        cal[3] = 1'b0;
        ticks(45);

        // R9 asynchronous global reset in operation, R10 PLL hold
        rst_in = 1'b1;
        #1;
        chk(ana_rst == '1 && dig_rst == '1, "R9", "async assert", {ana_rst, dig_rst}, 8'hFF);
        ticks(3);
        rst_in = 1'b0;
        ticks(2);
        chk(pll_pd == '1, "R10", "pll held after release", pll_pd, 2'b11);
        ticks(60);
        chk(ready == '1 && pll_pd == '0, "R10", "final state", {ready, pll_pd}, 6'b111100);

        done = 1;
        summary();
        $finish;
    end
endmodule